// File: doc/BRIEF.md
# Address-Range Monitor Wait Controller

This block holds the control side of a core's monitor-and-wait idle feature. An arm command records the 64-byte line that software wants to watch. A later wait command, which carries a hint word and an extension word, decides whether the core may drop into an optimized idle state. While the core is idle, the block watches snooped store addresses, external interrupt requests and a vector of architectural event lines. When a wake condition arrives it leaves the idle state and signals that execution continues past the wait.

The block raises an invalid-opcode fault for a wait that is not allowed. That covers the wrong privilege level, the feature switched off, an unsupported extension bit, or reserved extension bits. A wait that cannot sleep, because nothing is armed or because the watched line was already written, completes at once. Every completion carries a 4-bit wake-reason code. The actual gating of clocks or power, the delivery of interrupts and cache coherence are handled elsewhere.

Top module: `mwait_ctrl`

## Requirements
- R1: A wait command accepted while `wait_priv` is not 0 raises `fault_ud` for one cycle in the next cycle, with `idle_req` and `done` held at 0.
- R2: While `mw_enable` is 0, `cap_flag` reads 0 and every wait command raises `fault_ud` in the next cycle. While `mw_enable` is 1, `cap_flag` reads 1.
- R3: A wait with `wait_ext[0]`=1 while `brk_cap` is 0 raises `fault_ud`. A wait with any of `wait_ext[EXT_W-1:1]` set also raises `fault_ud`.
- R4: A legal wait issued when no successful arm is in force (no arm since reset, or the last arm had `arm_ok`=0) does not set `idle_req`. It pulses `done` in the next cycle with `wake_code`=0.
- R5: A snooped store to the armed line after arming and before the wait makes the next legal wait complete at once: `done` in the next cycle with `wake_code`=1 and no idle state.
- R6: Otherwise a legal wait sets `idle_req` in the next cycle, and `idle_hint` equals the hint word given with the wait.
- R7: While idle, a snooped store ends the idle state only if bits ADDR_W-1..6 of its address equal those of the armed address. Such a store gives `wake_code`=2.
- R8: While idle, any asserted `evt_lines[i]` ends the idle state with `wake_code`=8+i. The lowest asserted index wins, and events take priority over stores and interrupts. The bit order is NMI, SMI, debug, machine check, INIT, RESET, bus-init.
- R9: While idle, an `irq_req` with `irq_masked`=0 ends the idle state with `wake_code`=3. A masked request ends it only if the wait had `wait_ext[0]`=1. A store hit has priority over an interrupt.
- R10: Every completion clears the armed state, so the next wait without a new arm completes with `wake_code`=0.
- R11: Leaving the idle state always pulses `done` in the cycle in which `idle_req` falls. `done` and `fault_ud` are never high together. After any wake, including SMI, the block never re-enters the idle state without a new wait command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mw_enable | input | 1 | Software enable for the monitor-wait feature |
| brk_cap | input | 1 | Capability: masked interrupts may act as break events |
| cap_flag | output | 1 | Feature-available flag |
| arm_valid | input | 1 | Arm command strobe |
| arm_ok | input | 1 | The arm command succeeded |
| arm_addr | input | ADDR_W | Address to monitor |
| wait_valid | input | 1 | Wait command strobe (ignored while idle) |
| wait_priv | input | 2 | Privilege level of the wait |
| wait_hint | input | HINT_W | Requested idle-state hint |
| wait_ext | input | EXT_W | Extension word; bit 0 enables masked-interrupt wake |
| snoop_valid | input | 1 | A snooped store is present |
| snoop_addr | input | ADDR_W | Snooped store address |
| irq_req | input | 1 | External interrupt request |
| irq_masked | input | 1 | The interrupt is currently masked |
| evt_lines | input | NUM_EVT | Architectural wake events |
| idle_req | output | 1 | Request to hold the optimized idle state |
| idle_hint | output | HINT_W | Latched hint of the current wait |
| done | output | 1 | Completion pulse: continue after the wait |
| wake_code | output | 4 | Completion reason, valid with `done` |
| fault_ud | output | 1 | Invalid-opcode fault pulse |

## Verification
The checker watches every cycle for the fault responses to an illegal privilege, a disabled feature and an unsupported extension bit. It also checks that event lines and unmasked interrupts always end the idle state in the next cycle. On every cycle it checks that a drop of `idle_req` comes with `done` and that `done` never coincides with a fault. The bench's scenarios are needed for the rest: the armed-line comparison and the pre-wait trigger, priority among simultaneous wake sources, masked-interrupt wake depending on the latched extension bit, hint capture, and clearing of the armed state after each completion.

// File: rtl/mwait_pkg.sv
// Package: shared constants for the monitor-wait controller.
// Assumes a 64-byte monitored line and a 4-bit wake-reason code.
package mwait_pkg;
    localparam int LINE_LSB = 6;

    localparam logic [3:0] WK_UNARMED  = 4'd0;
    localparam logic [3:0] WK_PRETRIG  = 4'd1;
    localparam logic [3:0] WK_STORE    = 4'd2;
    localparam logic [3:0] WK_IRQ      = 4'd3;
    localparam logic [3:0] WK_EVT_BASE = 4'd8;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_SLEEP = 1'b1
    } mw_state_e;
endpackage

// File: rtl/mwait_range_match.sv
// Module: compares a snooped store address with the armed address at line
// granularity. Assumes the armed address is held stable by the caller.
module mwait_range_match
    import mwait_pkg::*;
#(
    parameter int ADDR_W = 48
) (
    input  logic              armed,
    input  logic [ADDR_W-1:0] armed_addr,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              hit
);
    logic [ADDR_W-1:0] diff;

    // Purpose: flag a store whose line bits equal the armed line.
    always_comb begin
        diff = (snoop_addr ^ armed_addr) >> LINE_LSB;
        hit  = armed && snoop_valid && (diff == '0);
    end
endmodule

// File: rtl/mwait_cmd_check.sv
// Module: decides whether a wait command is legal. Assumes the extension word
// has at least two bits and that only bit 0 is defined.
module mwait_cmd_check #(
    parameter int EXT_W = 32
) (
    input  logic [1:0]       priv,
    input  logic             enable,
    input  logic             brk_cap,
    input  logic [EXT_W-1:0] ext,
    output logic             illegal
);
    // Purpose: combine privilege, enable, capability and reserved-bit tests.
    always_comb begin
        illegal = (priv != 2'd0) || !enable
               || (ext[0] && !brk_cap)
               || (ext[EXT_W-1:1] != '0);
    end
endmodule

// File: rtl/mwait_wake_arb.sv
// Module: selects the wake reason while idle. Events win over stores, and
// stores win over interrupts. The lowest event index wins. Assumes NUM_EVT <= 8.
module mwait_wake_arb
    import mwait_pkg::*;
#(
    parameter int NUM_EVT = 7
) (
    input  logic [NUM_EVT-1:0] evt,
    input  logic               store_hit,
    input  logic               irq_req,
    input  logic               irq_masked,
    input  logic               brk_masked,
    output logic               wake,
    output logic [3:0]         code
);
    logic irq_wake;

    // Purpose: priority-encode the wake sources into one reason code.
    always_comb begin
        irq_wake = irq_req && (!irq_masked || brk_masked);
        wake     = 1'b0;
        code     = WK_UNARMED;
        if (irq_wake) begin
            wake = 1'b1;
            code = WK_IRQ;
        end
        if (store_hit) begin
            wake = 1'b1;
            code = WK_STORE;
        end
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (evt[i]) begin
                wake = 1'b1;
                code = WK_EVT_BASE | 4'(i);
            end
        end
    end
endmodule

// File: rtl/mwait_ctrl.sv
// Module: top of the monitor-wait controller. It holds the armed line, the
// pre-wait trigger and the run/sleep state, and it issues completion and fault
// pulses. Assumes one command per cycle; a wait wins over an arm in the same
// cycle, and commands are ignored while idle.
module mwait_ctrl
    import mwait_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int HINT_W  = 32,
    parameter int EXT_W   = 32,
    parameter int NUM_EVT = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mw_enable,
    input  logic               brk_cap,
    output logic               cap_flag,
    input  logic               arm_valid,
    input  logic               arm_ok,
    input  logic [ADDR_W-1:0]  arm_addr,
    input  logic               wait_valid,
    input  logic [1:0]         wait_priv,
    input  logic [HINT_W-1:0]  wait_hint,
    input  logic [EXT_W-1:0]   wait_ext,
    input  logic               snoop_valid,
    input  logic [ADDR_W-1:0]  snoop_addr,
    input  logic               irq_req,
    input  logic               irq_masked,
    input  logic [NUM_EVT-1:0] evt_lines,
    output logic               idle_req,
    output logic [HINT_W-1:0]  idle_hint,
    output logic               done,
    output logic [3:0]         wake_code,
    output logic               fault_ud
);
    mw_state_e         state_q;
    logic              armed_q;
    logic              trig_q;
    logic [ADDR_W-1:0] addr_q;
    logic [HINT_W-1:0] hint_q;
    logic              brk_q;
    logic              done_q;
    logic              fault_q;
    logic [3:0]        code_q;

    logic              hit;
    logic              illegal;
    logic              wake;
    logic [3:0]        wake_sel;

    mwait_range_match #(.ADDR_W(ADDR_W)) u_match (
        .armed       (armed_q),
        .armed_addr  (addr_q),
        .snoop_valid (snoop_valid),
        .snoop_addr  (snoop_addr),
        .hit         (hit)
    );

    mwait_cmd_check #(.EXT_W(EXT_W)) u_check (
        .priv    (wait_priv),
        .enable  (mw_enable),
        .brk_cap (brk_cap),
        .ext     (wait_ext),
        .illegal (illegal)
    );

    mwait_wake_arb #(.NUM_EVT(NUM_EVT)) u_arb (
        .evt        (evt_lines),
        .store_hit  (hit),
        .irq_req    (irq_req),
        .irq_masked (irq_masked),
        .brk_masked (brk_q),
        .wake       (wake),
        .code       (wake_sel)
    );

    // Purpose: sequence arm, wait, sleep and wake, with single-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            armed_q <= 1'b0;
            trig_q  <= 1'b0;
            addr_q  <= '0;
            hint_q  <= '0;
            brk_q   <= 1'b0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            code_q  <= WK_UNARMED;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            case (state_q)
                ST_RUN: begin
                    if (wait_valid) begin
                        if (illegal) begin
                            fault_q <= 1'b1;
                        end else if (!armed_q) begin
                            done_q <= 1'b1;
                            code_q <= WK_UNARMED;
                        end else if (trig_q || hit) begin
                            done_q  <= 1'b1;
                            code_q  <= WK_PRETRIG;
                            armed_q <= 1'b0;
                            trig_q  <= 1'b0;
                        end else begin
                            state_q <= ST_SLEEP;
                            hint_q  <= wait_hint;
                            brk_q   <= wait_ext[0];
                        end
                    end else if (arm_valid) begin
                        armed_q <= arm_ok;
                        addr_q  <= arm_addr;
                        trig_q  <= 1'b0;
                    end else if (hit) begin
                        trig_q <= 1'b1;
                    end
                end
                ST_SLEEP: begin
                    if (wake) begin
                        state_q <= ST_RUN;
                        done_q  <= 1'b1;
                        code_q  <= wake_sel;
                        armed_q <= 1'b0;
                        trig_q  <= 1'b0;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // Purpose: drive the outputs from the registered state.
    always_comb begin
        cap_flag  = mw_enable;
        idle_req  = (state_q == ST_SLEEP);
        idle_hint = hint_q;
        done      = done_q;
        wake_code = code_q;
        fault_ud  = fault_q;
    end
endmodule

// File: rtl/mwait_ctrl_chk.sv
// Module: checker for mwait_ctrl, attached by bind. It only observes ports.
module mwait_ctrl_chk #(
    parameter int EXT_W   = 32,
    parameter int NUM_EVT = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mw_enable,
    input logic               brk_cap,
    input logic               wait_valid,
    input logic [1:0]         wait_priv,
    input logic [EXT_W-1:0]   wait_ext,
    input logic               irq_req,
    input logic               irq_masked,
    input logic [NUM_EVT-1:0] evt_lines,
    input logic               idle_req,
    input logic               done,
    input logic [3:0]         wake_code,
    input logic               fault_ud
);
    p_priv_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_valid && !idle_req && wait_priv != 2'd0)
        |=> (fault_ud && !idle_req && !done));

    p_off_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_valid && !idle_req && !mw_enable) |=> (fault_ud && !idle_req));

    p_ext_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_valid && !idle_req && wait_ext[0] && !brk_cap) |=> fault_ud);

    p_evt_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && (evt_lines != '0))
        |=> (done && !idle_req && wake_code[3]));

    p_irq_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && irq_req && !irq_masked) |=> (done && !idle_req));

    p_exit_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle_req) |-> done);

    p_no_clash_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!fault_ud && !idle_req));
endmodule

bind mwait_ctrl mwait_ctrl_chk #(.EXT_W(EXT_W), .NUM_EVT(NUM_EVT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mw_enable  (mw_enable),
    .brk_cap    (brk_cap),
    .wait_valid (wait_valid),
    .wait_priv  (wait_priv),
    .wait_ext   (wait_ext),
    .irq_req    (irq_req),
    .irq_masked (irq_masked),
    .evt_lines  (evt_lines),
    .idle_req   (idle_req),
    .done       (done),
    .wake_code  (wake_code),
    .fault_ud   (fault_ud)
);

// File: tb/tb_mwait_ctrl.sv
// Bench: directed corner cases plus seeded random scenarios against a model.
module tb_mwait_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mw_enable = 1'b1, brk_cap = 1'b1;
    logic        cap_flag;
    logic        arm_valid = 1'b0, arm_ok = 1'b0;
    logic [47:0] arm_addr = '0;
    logic        wait_valid = 1'b0;
    logic [1:0]  wait_priv = '0;
    logic [31:0] wait_hint = '0, wait_ext = '0;
    logic        snoop_valid = 1'b0;
    logic [47:0] snoop_addr = '0;
    logic        irq_req = 1'b0, irq_masked = 1'b0;
    logic [6:0]  evt_lines = '0;
    logic        idle_req, done, fault_ud;
    logic [31:0] idle_hint;
    logic [3:0]  wake_code;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    bit          m_armed = 0, m_trig = 0, m_brk = 0;
    logic [47:0] m_addr = '0;

    always #10 clk = ~clk;

    mwait_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mw_enable(mw_enable), .brk_cap(brk_cap),
        .cap_flag(cap_flag), .arm_valid(arm_valid), .arm_ok(arm_ok),
        .arm_addr(arm_addr), .wait_valid(wait_valid), .wait_priv(wait_priv),
        .wait_hint(wait_hint), .wait_ext(wait_ext), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .irq_req(irq_req), .irq_masked(irq_masked),
        .evt_lines(evt_lines), .idle_req(idle_req), .idle_hint(idle_hint),
        .done(done), .wake_code(wake_code), .fault_ud(fault_ud)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit same_line(input logic [47:0] a, input logic [47:0] b);
        return (a >> 6) == (b >> 6);
    endfunction

    // Expected {wake, code} while idle, from R7, R8 and R9.
    function automatic logic [4:0] exp_wake(input logic [6:0] ev, input bit sv,
                                            input logic [47:0] sa, input bit iq,
                                            input bit mk);
        for (int i = 0; i < 7; i++)
            if (ev[i]) return {1'b1, 4'(8 + i)};
        if (sv && same_line(sa, m_addr)) return {1'b1, 4'd2};
        if (iq && (!mk || m_brk)) return {1'b1, 4'd3};
        return 5'd0;
    endfunction

    task automatic do_arm(input logic [47:0] a, input bit ok);
        @(negedge clk);
        arm_valid = 1'b1; arm_addr = a; arm_ok = ok;
        @(negedge clk);
        arm_valid = 1'b0;
        m_armed = ok; m_addr = a; m_trig = 0;
    endtask

    task automatic do_snoop(input logic [47:0] a);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = a;
        @(negedge clk);
        snoop_valid = 1'b0;
        if (m_armed && same_line(a, m_addr)) m_trig = 1;
    endtask

    task automatic do_wait(input logic [31:0] h, input logic [31:0] e,
                           input logic [1:0] p, output bit slept);
        string tag;
        bit bad;
        slept = 0;
        @(negedge clk);
        wait_valid = 1'b1; wait_hint = h; wait_ext = e; wait_priv = p;
        @(negedge clk);
        wait_valid = 1'b0;
        bad = (p != 0) || !mw_enable || (e[0] && !brk_cap) || (e[31:1] != 0);
        if (bad) begin
            tag = (p != 0) ? "R1" : (!mw_enable ? "R2" : "R3");
            chk(tag, "fault_ud", fault_ud, 1);
            chk(tag, "done", done, 0);
            chk(tag, "idle_req", idle_req, 0);
        end else if (!m_armed) begin
            chk("R4", "done", done, 1);
            chk("R4", "wake_code", wake_code, 0);
            chk("R4", "idle_req", idle_req, 0);
        end else if (m_trig) begin
            chk("R5", "done", done, 1);
            chk("R5", "wake_code", wake_code, 1);
            chk("R5", "idle_req", idle_req, 0);
            m_armed = 0; m_trig = 0;
        end else begin
            chk("R6", "idle_req", idle_req, 1);
            chk("R6", "idle_hint", idle_hint, h);
            chk("R6", "done", done, 0);
            slept = 1; m_brk = e[0];
        end
    endtask

    task automatic do_wake(input logic [6:0] ev, input bit sv, input logic [47:0] sa,
                           input bit iq, input bit mk, output bit woke);
        logic [4:0] x;
        string tag;
        x = exp_wake(ev, sv, sa, iq, mk);
        tag = (ev != 0) ? "R8" : ((sv && same_line(sa, m_addr)) ? "R7" : "R9");
        @(negedge clk);
        evt_lines = ev; snoop_valid = sv; snoop_addr = sa;
        irq_req = iq; irq_masked = mk;
        @(negedge clk);
        evt_lines = '0; snoop_valid = 1'b0; irq_req = 1'b0; irq_masked = 1'b0;
        woke = x[4];
        chk(tag, "done", done, x[4]);
        chk("R11", "idle_req", idle_req, !x[4]);
        if (x[4]) begin
            chk(tag, "wake_code", wake_code, x[3:0]);
            m_armed = 0; m_trig = 0;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog: actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit s, w;
        logic [47:0] base;
        process::self().srandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        chk("R11", "reset idle_req", idle_req, 0);
        chk("R11", "reset done", done, 0);
        chk("R1", "reset fault", fault_ud, 0);
        chk("R2", "cap_flag on", cap_flag, 1);

        // R4: no arm, then a failed arm.
        do_wait(32'h11, 0, 0, s);
        do_arm(48'h1000, 0);
        do_wait(32'h12, 0, 0, s);

        // R5 then R10: store to the armed line before the wait.
        do_arm(48'h2040, 1);
        do_snoop(48'h207f);
        do_wait(32'h13, 0, 0, s);
        do_wait(32'h14, 0, 0, s);

        // R6/R7: sleep, miss on the next line, hit on the last byte.
        do_arm(48'h3000, 1);
        do_wait(32'hA5A5_0023, 0, 0, s);
        do_wake(0, 1, 48'h3040, 0, 0, w);
        do_wake(0, 1, 48'h303f, 0, 0, w);
        @(negedge clk);
        chk("R11", "done single pulse", done, 0);
        do_wait(32'h15, 0, 0, s);

        // R9: masked interrupt ignored without ext bit 0, then unmasked wakes.
        do_arm(48'h4000, 1);
        do_wait(32'h16, 0, 0, s);
        do_wake(0, 0, 0, 1, 1, w);
        do_wake(0, 0, 0, 1, 0, w);
        // R9: masked interrupt wakes with ext bit 0.
        do_arm(48'h4000, 1);
        do_wait(32'h17, 1, 0, s);
        do_wake(0, 0, 0, 1, 1, w);
        // R8: events win over store and interrupt; index 4 beats 5.
        do_arm(48'h5000, 1);
        do_wait(32'h18, 0, 0, s);
        do_wake(7'h30, 1, 48'h5000, 1, 0, w);
        // R9: store beats interrupt.
        do_arm(48'h5000, 1);
        do_wait(32'h19, 0, 0, s);
        do_wake(0, 1, 48'h5001, 1, 0, w);
        // R11: SMI wake, no re-entry afterwards.
        do_arm(48'h6000, 1);
        do_wait(32'h1a, 0, 0, s);
        do_wake(7'h02, 0, 0, 0, 0, w);
        repeat (3) @(negedge clk);
        chk("R11", "no re-entry after SMI", idle_req, 0);

        // R1, R2, R3 faults.
        do_arm(48'h7000, 1);
        do_wait(32'h1b, 0, 3, s);
        mw_enable = 1'b0;
        @(negedge clk);
        chk("R2", "cap_flag off", cap_flag, 0);
        do_wait(32'h1c, 0, 0, s);
        mw_enable = 1'b1;
        brk_cap = 1'b0;
        do_wait(32'h1d, 1, 0, s);
        brk_cap = 1'b1;
        do_wait(32'h1e, 32'h20, 0, s);
        do_wait(32'h1f, 0, 0, s);
        if (s) do_wake(7'h01, 0, 0, 0, 0, w);

        // Random scenarios.
        for (int it = 0; it < 300; it++) begin
            logic [31:0] ext;
            logic [1:0]  pv;
            mw_enable = ($urandom % 8) != 0;
            brk_cap   = $urandom % 2;
            base = {$urandom, $urandom};
            do_arm(base, ($urandom % 4) != 0);
            if ($urandom % 4 == 0) begin
                if ($urandom % 2) do_snoop({base[47:6], 6'($urandom)});
                else do_snoop(base ^ (48'd1 << (6 + $urandom % 42)));
            end
            pv  = ($urandom % 6 == 0) ? 2'(1 + $urandom % 3) : 2'd0;
            ext = {31'd0, 1'($urandom % 3 == 0)};
            if ($urandom % 10 == 0) ext[1 + $urandom % 31] = 1'b1;
            do_wait($urandom, ext, pv, s);
            if (s) begin
                w = 0;
                for (int k = 0; k < 3 && !w; k++) begin
                    logic [47:0] sa;
                    sa = ($urandom % 2) ? {m_addr[47:6], 6'($urandom)}
                                        : m_addr ^ (48'd1 << (6 + $urandom % 42));
                    do_wake(($urandom % 3 == 0) ? 7'($urandom) : 7'd0,
                            $urandom % 2, sa, $urandom % 2, $urandom % 2, w);
                end
                if (!w) do_wake(7'd1 << ($urandom % 7), 0, 0, 0, 0, w);
            end
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule